// File: doc/BRIEF.md
# Four-Digit Display Host Write Port and Storage

This block is the storage side of a four-digit dot-matrix character display that sits on a microprocessor bus. The host drives a 2-bit digit address, a 7-bit data word, two active-low enables, an active-low write strobe and a steering line. The block keeps four character codes, a cursor flag and a blank-override flag for each digit, and one shared control word. The control word holds a 3-bit brightness code, a master-blank flag and a flag that switches off the extended blanking and dimming features. All of these values are presented in parallel to the refresh and blanking logic downstream.

The bus pins are asynchronous to the system clock. The strobe and the clear pin each pass through a two-flop synchroniser. A rising edge of the synchronised strobe commits the address, data, steering and enable values that were sampled on the clock edge before that rising edge. An active-low clear loads a space code into every character cell and zeroes every flag. The clear works whatever the enables are doing, and it overrides a write that lands in the same cycle. Blanking is handled downstream, so it never affects what is stored here or whether it can be written.

Top module: `glyph_store_port`

## Requirements
- R1: After a clock edge with `rst_n` low, every 7-bit field of `char_codes` is 7'h20 and `cursor_bits`, `blank_hold`, `master_blank`, `bright_code` and `ext_off` are all zero.
- R2: A strobe cycle changes no stored value unless both `en_a_n` and `en_b_n` are low while the strobe is low.
- R3: With `cell_sel` = 1, the data word is stored as the character code of the addressed digit. Address 0 is the rightmost digit, held in `char_codes[6:0]`, and address 3 is the leftmost, held in `char_codes[27:21]`. No attribute or control value changes.
- R4: With `cell_sel` = 0, data bit 0 goes to `cursor_bits[addr]` and bit 1 to `blank_hold[addr]`. Bit 2 goes to `master_blank`, bits 5:3 to `bright_code`, and bit 6 to `ext_off`. Other digits' flags and all character codes are unchanged.
- R5: A write becomes visible after the third rising clock edge, counting as the first edge the one that first samples `wr_n` high after a low period. The edge before that third edge sets the data, address and steering values that are stored.
- R6: While `clr_n` is low, everything is loaded with the R1 values, whatever the enables are. This first happens on the third rising edge, counting as the first edge the one that first samples `clr_n` low, and it repeats on every edge while `clr_n` stays low.
- R7: When a clear and a write fall on the same clock edge, the clear wins and the write leaves no trace.
- R8: Digits can be written in any order. Rewriting one digit replaces only that digit and keeps the others.
- R9: While `wr_n` stays high and `clr_n` stays high, changes on address, data, steering and enable pins leave every stored value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 2 | Digit address, 0 is rightmost |
| host_data | input | 7 | Write data word |
| en_a_n | input | 1 | Active-low enable, first |
| en_b_n | input | 1 | Active-low enable, second |
| wr_n | input | 1 | Asynchronous active-low write strobe |
| cell_sel | input | 1 | 1 = character cell, 0 = attribute and control |
| clr_n | input | 1 | Asynchronous active-low clear |
| char_codes | output | 28 | Four 7-bit character codes, digit d at [7d+6:7d] |
| cursor_bits | output | 4 | Per-digit cursor flags |
| blank_hold | output | 4 | Per-digit blank-override flags |
| master_blank | output | 1 | Shared master-blank flag |
| bright_code | output | 3 | Brightness code, 0 is brightest |
| ext_off | output | 1 | Extended-feature disable flag |

## Verification
A committed write and an active clear can land on the same clock edge. The bench forces this by releasing the strobe and pulling the clear low at the same falling clock edge, after character and attribute writes have left non-default values. Both signals then run through synchronisers of equal depth and reach the storage together. After the clear is released, all storage must show space codes and zero flags, and a behavioural model compares the outputs on every cycle, so a write that leaks through and survives the clear is reported.

// File: rtl/glyph_store_pkg.sv
// Package: shared constants and types for the display host storage.
// Assumes a 7-bit host data word with fixed field positions for
// attribute/control writes.
package glyph_store_pkg;

    localparam int CODE_W     = 7;
    localparam logic [CODE_W-1:0] SPACE_CODE = 7'h20;

    // Field positions inside an attribute/control data word.
    localparam int CUR_POS    = 0;
    localparam int HOLD_POS   = 1;
    localparam int MBLANK_POS = 2;
    localparam int BRIGHT_LSB = 3;
    localparam int BRIGHT_W   = 3;
    localparam int EXTOFF_POS = 6;

    // Shared control word.
    typedef struct packed {
        logic                ext_off;
        logic [BRIGHT_W-1:0] bright;
        logic                master_blank;
    } ctrl_word_t;

    localparam ctrl_word_t CTRL_IDLE = '{ext_off: 1'b0, bright: '0, master_blank: 1'b0};

endpackage

// File: rtl/gs_sync.sv
// Module: multi-stage synchroniser for a bundle of asynchronous bits.
// Assumes each bit is independent (no multi-bit coherence needed).
// Reset value is all ones, which is the idle level of the active-low pins.
module gs_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [STAGES-1:0][WIDTH-1:0] chain;

    // Shift the asynchronous inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '1;
        end else begin
            chain[0] <= async_in;
            for (int s = 1; s < STAGES; s++) begin
                chain[s] <= chain[s-1];
            end
        end
    end

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/gs_strobe_capture.sv
// Module: detects the rising edge of the synchronised write strobe and
// produces a one-cycle write request. Bus fields are sampled on every
// edge while the synchronised strobe is still low, so the request carries
// the values from the clock edge just before the rising edge.
// Assumes the host keeps the bus fields steady through the strobe.
module gs_strobe_capture #(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_s_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              bus_sel,
    input  logic              bus_en_a_n,
    input  logic              bus_en_b_n,
    output logic              wr_fire,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_sel
);

    logic strobe_prev_n;
    logic cap_en_a_n;
    logic cap_en_b_n;

    // Remember the previous synchronised strobe level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_prev_n <= 1'b1;
        end else begin
            strobe_prev_n <= strobe_s_n;
        end
    end

    // Sample bus fields while the synchronised strobe is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_addr    <= '0;
            wr_data    <= '0;
            wr_sel     <= 1'b0;
            cap_en_a_n <= 1'b1;
            cap_en_b_n <= 1'b1;
        end else if (!strobe_s_n) begin
            wr_addr    <= bus_addr;
            wr_data    <= bus_data;
            wr_sel     <= bus_sel;
            cap_en_a_n <= bus_en_a_n;
            cap_en_b_n <= bus_en_b_n;
        end
    end

    // Request a write on a low-to-high strobe with both enables asserted.
    always_comb begin
        wr_fire = strobe_s_n && !strobe_prev_n && !cap_en_a_n && !cap_en_b_n;
    end

endmodule

// File: rtl/gs_char_bank.sv
// Module: per-digit character code registers.
// Assumes wipe has priority over a write in the same cycle.
module gs_char_bank
    import glyph_store_pkg::*;
#(
    parameter int N_DIGITS = 4,
    parameter int ADDR_W   = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wipe,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [CODE_W-1:0]          wr_data,
    output logic [N_DIGITS*CODE_W-1:0] codes
);

    for (genvar d = 0; d < N_DIGITS; d++) begin : g_cell
        logic hit;

        // Decode whether this digit is the write target.
        always_comb begin
            hit = wr_en && (wr_addr == ADDR_W'(d));
        end

        // Hold one character code; clear loads the space code.
        always_ff @(posedge clk) begin
            if (!rst_n || wipe) begin
                codes[d*CODE_W +: CODE_W] <= SPACE_CODE;
            end else if (hit) begin
                codes[d*CODE_W +: CODE_W] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/gs_attr_ctrl.sv
// Module: per-digit cursor / blank-override flags and the shared control
// word, all written from one data word.
// Assumes wipe has priority over a write in the same cycle.
module gs_attr_ctrl
    import glyph_store_pkg::*;
#(
    parameter int N_DIGITS = 4,
    parameter int ADDR_W   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wipe,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [CODE_W-1:0]   wr_data,
    output logic [N_DIGITS-1:0] cursor,
    output logic [N_DIGITS-1:0] hold,
    output ctrl_word_t          ctrl
);

    for (genvar d = 0; d < N_DIGITS; d++) begin : g_attr
        logic hit;

        // Decode whether this digit's flag pair is the write target.
        always_comb begin
            hit = wr_en && (wr_addr == ADDR_W'(d));
        end

        // Hold the cursor and blank-override flags of one digit.
        always_ff @(posedge clk) begin
            if (!rst_n || wipe) begin
                cursor[d] <= 1'b0;
                hold[d]   <= 1'b0;
            end else if (hit) begin
                cursor[d] <= wr_data[CUR_POS];
                hold[d]   <= wr_data[HOLD_POS];
            end
        end
    end

    // Hold the shared control word; any attribute write refreshes it.
    always_ff @(posedge clk) begin
        if (!rst_n || wipe) begin
            ctrl <= CTRL_IDLE;
        end else if (wr_en) begin
            ctrl.master_blank <= wr_data[MBLANK_POS];
            ctrl.bright       <= wr_data[BRIGHT_LSB +: BRIGHT_W];
            ctrl.ext_off      <= wr_data[EXTOFF_POS];
        end
    end

endmodule

// File: rtl/glyph_store_port.sv
// Module: host write port and storage of a four-digit dot-matrix display.
// Synchronises the asynchronous strobe and clear, turns a strobe rising
// edge into a one-cycle write, and steers it to the character cells or
// to the attribute/control storage. All stored values leave in parallel.
// Assumes bus fields are stable around the strobe rising edge.
module glyph_store_port
    import glyph_store_pkg::*;
#(
    parameter int N_DIGITS    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [$clog2(N_DIGITS)-1:0]  host_addr,
    input  logic [CODE_W-1:0]            host_data,
    input  logic                         en_a_n,
    input  logic                         en_b_n,
    input  logic                         wr_n,
    input  logic                         cell_sel,
    input  logic                         clr_n,
    output logic [N_DIGITS*CODE_W-1:0]   char_codes,
    output logic [N_DIGITS-1:0]          cursor_bits,
    output logic [N_DIGITS-1:0]          blank_hold,
    output logic                         master_blank,
    output logic [BRIGHT_W-1:0]          bright_code,
    output logic                         ext_off
);

    localparam int ADDR_W = $clog2(N_DIGITS);

    logic [1:0]        pins_s;
    logic              strobe_s_n;
    logic              wipe_act;
    logic              wr_fire;
    logic [ADDR_W-1:0] wr_addr;
    logic [CODE_W-1:0] wr_data;
    logic              wr_sel;
    logic              char_we;
    logic              attr_we;
    ctrl_word_t        ctrl;

    gs_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({clr_n, wr_n}),
        .sync_out (pins_s)
    );

    // Split the synchronised pins into strobe and clear request.
    always_comb begin
        strobe_s_n = pins_s[0];
        wipe_act   = !pins_s[1];
    end

    gs_strobe_capture #(
        .ADDR_W (ADDR_W),
        .DATA_W (CODE_W)
    ) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe_s_n (strobe_s_n),
        .bus_addr   (host_addr),
        .bus_data   (host_data),
        .bus_sel    (cell_sel),
        .bus_en_a_n (en_a_n),
        .bus_en_b_n (en_b_n),
        .wr_fire    (wr_fire),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .wr_sel     (wr_sel)
    );

    // Steer the write request to one of the two storage groups.
    always_comb begin
        char_we = wr_fire && wr_sel;
        attr_we = wr_fire && !wr_sel;
    end

    gs_char_bank #(
        .N_DIGITS (N_DIGITS),
        .ADDR_W   (ADDR_W)
    ) u_chars (
        .clk     (clk),
        .rst_n   (rst_n),
        .wipe    (wipe_act),
        .wr_en   (char_we),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .codes   (char_codes)
    );

    gs_attr_ctrl #(
        .N_DIGITS (N_DIGITS),
        .ADDR_W   (ADDR_W)
    ) u_attr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wipe    (wipe_act),
        .wr_en   (attr_we),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cursor  (cursor_bits),
        .hold    (blank_hold),
        .ctrl    (ctrl)
    );

    // Unpack the control word onto its output pins.
    always_comb begin
        master_blank = ctrl.master_blank;
        bright_code  = ctrl.bright;
        ext_off      = ctrl.ext_off;
    end

endmodule

// File: rtl/glyph_store_chk.sv
// Module: property checker for glyph_store_port, attached by bind.
// Observes the internal write request and clear request against the
// stored outputs.
module glyph_store_chk #(
    parameter int N_DIGITS = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wipe_act,
    input logic                  wr_fire,
    input logic                  wr_sel,
    input logic [N_DIGITS*7-1:0] char_codes,
    input logic [N_DIGITS-1:0]   cursor_bits,
    input logic [N_DIGITS-1:0]   blank_hold,
    input logic                  master_blank,
    input logic [2:0]            bright_code,
    input logic                  ext_off
);

    // R1: reset leaves space codes and zero flags
    a_r1_reset_space: assert property (@(posedge clk)
        !rst_n |=> (char_codes == {N_DIGITS{7'h20}}) && (cursor_bits == '0) && (blank_hold == '0));

    // R6: an active clear defaults all storage on the next edge
    a_r6_clear_defaults: assert property (@(posedge clk) disable iff (!rst_n)
        wipe_act |=> (char_codes == {N_DIGITS{7'h20}}) && (cursor_bits == '0) && (blank_hold == '0)
                     && !master_blank && (bright_code == '0) && !ext_off);

    // R7: a write coinciding with a clear leaves the characters as spaces
    a_r7_clear_beats_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wipe_act && wr_fire) |=> (char_codes == {N_DIGITS{7'h20}}));

    // R9: without a write or clear nothing stored moves
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_fire && !wipe_act) |=> $stable(char_codes) && $stable(cursor_bits) && $stable(blank_hold)
                                    && $stable(master_blank) && $stable(bright_code) && $stable(ext_off));

    // R3: a character write leaves attributes and control alone
    a_r3_char_only: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && wr_sel && !wipe_act) |=> $stable(cursor_bits) && $stable(blank_hold)
                                             && $stable(master_blank) && $stable(bright_code) && $stable(ext_off));

    // R4: an attribute/control write leaves characters alone
    a_r4_attr_only: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && !wr_sel && !wipe_act) |=> $stable(char_codes));

    // R5: one strobe edge gives a single-cycle write request
    a_r5_single_fire: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fire |=> !wr_fire);

endmodule

bind glyph_store_port glyph_store_chk #(.N_DIGITS(N_DIGITS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wipe_act     (wipe_act),
    .wr_fire      (wr_fire),
    .wr_sel       (wr_sel),
    .char_codes   (char_codes),
    .cursor_bits  (cursor_bits),
    .blank_hold   (blank_hold),
    .master_blank (master_blank),
    .bright_code  (bright_code),
    .ext_off      (ext_off)
);

// File: tb/glyph_store_port_test.sv
module glyph_store_port_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  host_addr = '0;
    logic [6:0]  host_data = '0;
    logic        en_a_n = 1'b1;
    logic        en_b_n = 1'b1;
    logic        wr_n = 1'b1;
    logic        cell_sel = 1'b0;
    logic        clr_n = 1'b1;
    logic [27:0] char_codes;
    logic [3:0]  cursor_bits;
    logic [3:0]  blank_hold;
    logic        master_blank;
    logic [2:0]  bright_code;
    logic        ext_off;

    int checks = 0;
    int fails = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    glyph_store_port uut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_data(host_data),
        .en_a_n(en_a_n), .en_b_n(en_b_n), .wr_n(wr_n), .cell_sel(cell_sel), .clr_n(clr_n),
        .char_codes(char_codes), .cursor_bits(cursor_bits), .blank_hold(blank_hold),
        .master_blank(master_blank), .bright_code(bright_code), .ext_off(ext_off)
    );

    // Behavioural reference: pin history queues, latency counted from the requirements.
    bit         q_wr[$];
    bit         q_clr[$];
    logic [6:0] m_char[4];
    bit         m_cur[4];
    bit         m_hold[4];
    bit         m_mb;
    int         m_br;
    bit         m_ext;
    logic [1:0] p_addr;
    logic [6:0] p_data;
    bit         p_sel, p_ea, p_eb;

    task automatic model_defaults();
        for (int d = 0; d < 4; d++) begin
            m_char[d] = 7'h20; m_cur[d] = 0; m_hold[d] = 0;
        end
        m_mb = 0; m_br = 0; m_ext = 0;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            model_defaults();
            q_wr  = '{1, 1, 1, 1};
            q_clr = '{1, 1, 1, 1};
        end else begin
            q_wr.push_front(wr_n);   void'(q_wr.pop_back());
            q_clr.push_front(clr_n); void'(q_clr.pop_back());
            if (q_clr[2] == 0) begin
                model_defaults();
            end else if (q_wr[2] == 1 && q_wr[3] == 0 && !p_ea && !p_eb) begin
                if (p_sel) begin
                    m_char[p_addr] = p_data;
                end else begin
                    m_cur[p_addr]  = p_data[0];
                    m_hold[p_addr] = p_data[1];
                    m_mb  = p_data[2];
                    m_br  = int'(p_data[5:3]);
                    m_ext = p_data[6];
                end
            end
        end
        p_addr = host_addr; p_data = host_data; p_sel = cell_sel;
        p_ea = en_a_n; p_eb = en_b_n;
    end

    // Per-cycle comparison against the reference, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            logic [27:0] ec;
            logic [3:0]  ecur, ehold;
            for (int d = 0; d < 4; d++) begin
                ec[d*7 +: 7] = m_char[d]; ecur[d] = m_cur[d]; ehold[d] = m_hold[d];
            end
            checks++;
            if (char_codes !== ec || cursor_bits !== ecur || blank_hold !== ehold ||
                master_blank !== m_mb || bright_code !== 3'(m_br) || ext_off !== m_ext) begin
                fails++;
                $display("FAIL %s model: got %h %b %b %b %0d %b exp %h %b %b %b %0d %b", cur_req,
                         char_codes, cursor_bits, blank_hold, master_blank, bright_code, ext_off,
                         ec, ecur, ehold, m_mb, m_br, m_ext);
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [1:0] a, input logic [6:0] d, input logic s,
                              input logic ea, input logic eb);
        @(negedge clk);
        host_addr = a; host_data = d; cell_sel = s; en_a_n = ea; en_b_n = eb; wr_n = 1'b0;
        repeat (3) @(negedge clk);
        wr_n = 1'b1;
        repeat (5) @(negedge clk);
        en_a_n = 1'b1; en_b_n = 1'b1;
    endtask

    function automatic logic [31:0] attr_pack();
        return {20'd0, cursor_bits, blank_hold, master_blank, bright_code, ext_off};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R1";
        chk("R1 chars", 32'(char_codes), 32'({4{7'h20}}));
        chk("R1 flags", attr_pack(), 32'd0);

        cur_req = "R8";
        host_write(2'd3, 7'h48, 1, 0, 0);
        host_write(2'd0, 7'h69, 1, 0, 0);
        host_write(2'd2, 7'h5A, 1, 0, 0);
        host_write(2'd1, 7'h30, 1, 0, 0);
        chk("R3 digit order", 32'(char_codes), 32'({7'h48, 7'h5A, 7'h30, 7'h69}));
        host_write(2'd0, 7'h71, 1, 0, 0);
        chk("R8 rewrite", 32'(char_codes), 32'({7'h48, 7'h5A, 7'h30, 7'h71}));

        cur_req = "R4";
        host_write(2'd2, 7'h57, 0, 0, 0);
        chk("R4 attr d2", attr_pack(), {20'd0, 4'b0100, 4'b0100, 1'b1, 3'd2, 1'b1});
        chk("R4 chars kept", 32'(char_codes), 32'({7'h48, 7'h5A, 7'h30, 7'h71}));
        host_write(2'd0, 7'h01, 0, 0, 0);
        chk("R4 attr d0", attr_pack(), {20'd0, 4'b0101, 4'b0100, 1'b0, 3'd0, 1'b0});
        host_write(2'd3, 7'h3A, 0, 0, 0);
        chk("R4 attr d3", attr_pack(), {20'd0, 4'b0101, 4'b1100, 1'b0, 3'd7, 1'b0});

        cur_req = "R2";
        host_write(2'd1, 7'h7F, 1, 1, 0);
        host_write(2'd1, 7'h7F, 0, 0, 1);
        chk("R2 chars", 32'(char_codes), 32'({7'h48, 7'h5A, 7'h30, 7'h71}));
        chk("R2 flags", attr_pack(), {20'd0, 4'b0101, 4'b1100, 1'b0, 3'd7, 1'b0});

        cur_req = "R9";
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            host_addr = 2'(i); host_data = 7'(i * 13); cell_sel = i[0];
            en_a_n = i[1]; en_b_n = i[2];
        end
        @(negedge clk);
        en_a_n = 1'b1; en_b_n = 1'b1;
        chk("R9 chars", 32'(char_codes), 32'({7'h48, 7'h5A, 7'h30, 7'h71}));
        chk("R9 flags", attr_pack(), {20'd0, 4'b0101, 4'b1100, 1'b0, 3'd7, 1'b0});

        cur_req = "R5";
        @(negedge clk);
        host_addr = 2'd1; host_data = 7'h42; cell_sel = 1; en_a_n = 0; en_b_n = 0; wr_n = 0;
        repeat (4) @(negedge clk);
        wr_n = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R5 before third edge", 32'(char_codes[13:7]), 32'h30);
        @(posedge clk);
        @(negedge clk);
        chk("R5 at third edge", 32'(char_codes[13:7]), 32'h42);
        repeat (3) @(negedge clk);
        en_a_n = 1; en_b_n = 1;

        cur_req = "R6";
        @(negedge clk);
        clr_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R6 before third edge", 32'(char_codes[13:7]), 32'h42);
        @(posedge clk);
        @(negedge clk);
        chk("R6 chars cleared", 32'(char_codes), 32'({4{7'h20}}));
        chk("R6 flags cleared", attr_pack(), 32'd0);
        repeat (3) @(negedge clk);
        clr_n = 1'b1;
        repeat (4) @(negedge clk);

        cur_req = "R7";
        host_write(2'd3, 7'h55, 1, 0, 0);
        host_write(2'd1, 7'h7F, 0, 0, 0);
        @(negedge clk);
        host_addr = 2'd2; host_data = 7'h41; cell_sel = 1; en_a_n = 0; en_b_n = 0; wr_n = 0;
        repeat (4) @(negedge clk);
        wr_n = 1'b1; clr_n = 1'b0;
        repeat (5) @(negedge clk);
        clr_n = 1'b1; en_a_n = 1; en_b_n = 1;
        repeat (4) @(negedge clk);
        chk("R7 chars", 32'(char_codes), 32'({4{7'h20}}));
        chk("R7 flags", attr_pack(), 32'd0);

        cur_req = "R3";
        host_write(2'd2, 7'h41, 1, 0, 0);
        chk("R3 after clear", 32'(char_codes), 32'({7'h20, 7'h41, 7'h20, 7'h20}));
        chk("R3 flags untouched", attr_pack(), 32'd0);

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule